// File: doc/BRIEF.md
# Two-Channel Reloadable Countdown Timer

This peripheral sits on a simple 32-bit register bus and provides two independent down-counters. Each channel keeps a control word, a software-written load value and a read-only live count. The live count drops by one on every tick from the tick source the channel has selected. The selected source is either every clock cycle or an external slow strobe that stands in for a low-frequency oscillator. When the count passes from one to zero, the channel raises a status flag. If its enable bit is set, that flag contributes to a single combined interrupt line.

A channel can stop at zero and wait to be loaded again (one-shot use). It can instead reload from its load value and run periodically. A control bit decides whether writing the load value also restarts the live count at once. Besides the normal write, the control word has three alias addresses that set, clear or toggle only the bits given in the write data. Software therefore can acknowledge the flag without a read-modify-write. A global register offers a soft reset, and a fixed version word identifies the block.

The bus is a single-cycle write strobe with address and data. Read data is a combinational function of the address.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every channel register reads 0 and `irq` is low. The version word at offset 0xA0 reads 0x02000000, which is major version 2 in bits [31:24].
- R2: Channel n has its control word at 0x20+n*0x40, its live count at 0x30+n*0x40 and its load value at 0x40+n*0x40. Control bits [3:0] select the tick source: 0xF counts on every clock, 0xB counts on clocks where `slow_tick` is high, and any other value does not count. Each tick lowers a non-zero live count by exactly one.
- R3: The status flag (control bit 15) is set on the tick that takes the live count from 1 to 0. If reload (bit 6) is clear, the count then stays at 0.
- R4: If reload is set, a tick at a live count of 0 loads the load value. A load value of 0xFFFFFFFF therefore wraps the count from 0 to 0xFFFFFFFF and continues down from there.
- R5: If update (bit 7) is set, a write to the load value also puts the written value into the live count on the same clock edge. If update is clear, the live count is untouched by that write.
- R6: The control word has four addresses: base+0x0 writes it, base+0x4 sets the bits given in the data, base+0x8 clears them and base+0xC toggles them. Only bits [3:0], 6, 7, 14 and 15 exist, and all other bits read 0 whatever is written.
- R7: `irq` is high whenever some channel has both bit 15 and bit 14 set.
- R8: Writing the global register at 0x00 with bit 31 set returns every channel register to 0. The global register itself reads 0.
- R9: When a 1-to-0 tick and a write that clears bit 15 fall in the same cycle, the flag ends up set. When a load-with-update write and a tick fall in the same cycle, the written value wins over the decrement.
- R10: The live-count address is read-only, and writes to it change neither the live count nor the load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| slow_tick | input | 1 | Slow tick strobe used by source select 0xB |
| irq | output | 1 | Combined interrupt |

## Verification
Two collisions are checked. In the first, a channel's count reaches zero and its flag is set by hardware in the same cycle that software clears that flag through the clear alias. In the second, a load-with-update write lands on a cycle where the channel would also decrement. The bench provokes both by counting ticks exactly, so that the alias or load write is driven on the edge where the count is known to be 1 or non-zero. It then judges the results by reading the control word and the live count afterwards: the flag must be set, and the count must equal the written value rather than the value less one.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TGL = 2'd3
  } ctrl_op_e;

  localparam int BUS_W      = 32;
  localparam int SEL_W      = 4;
  localparam int RELOAD_BIT = 6;
  localparam int UPDATE_BIT = 7;
  localparam int IE_BIT     = 14;
  localparam int ST_BIT     = 15;
  localparam int SRST_BIT   = 31;

  localparam logic [BUS_W-1:0] CTRL_MASK = 32'h0000_C0CF;
  localparam logic [SEL_W-1:0] SEL_SLOW   = 4'hB;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'hF;
  localparam logic [7:0]       VER_MAJOR  = 8'h02;

  localparam int CH_BASE   = 32'h20;
  localparam int CH_STRIDE = 32'h40;
  localparam int RUN_OFF   = 32'h10;
  localparam int FIX_OFF   = 32'h20;

endpackage

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel
  import dtmr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             slow_tick,
  output logic             tick
);

  always_comb begin
    unique case (sel)
      SEL_ALWAYS: tick = 1'b1;
      SEL_SLOW:   tick = slow_tick;
      default:    tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             slow_tick,
  input  logic             ctrl_we,
  input  ctrl_op_e         ctrl_op,
  input  logic             fix_we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctrl_q,
  output logic [CNT_W-1:0] run_q,
  output logic [CNT_W-1:0] fix_q,
  output logic             irq_req
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic             tick;
  logic             load_now;
  logic             zero_hit;
  logic [BUS_W-1:0] ctrl_mod;
  logic [BUS_W-1:0] ctrl_d;
  logic [CNT_W-1:0] run_d;
  logic [CNT_W-1:0] fix_d;
  logic             ctrl_en;
  logic             run_en;
  logic             fix_en;

  dtmr_tick_sel u_tick (
    .sel       (ctrl_q[SEL_W-1:0]),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  // next-state logic
  always_comb begin
    ctrl_mod = ctrl_q;
    if (ctrl_we) begin
      unique case (ctrl_op)
        OP_WR:  ctrl_mod = wdata;
        OP_SET: ctrl_mod = ctrl_q | wdata;
        OP_CLR: ctrl_mod = ctrl_q & ~wdata;
        OP_TGL: ctrl_mod = ctrl_q ^ wdata;
      endcase
    end
    ctrl_mod = ctrl_mod & CTRL_MASK;

    load_now = fix_we && ctrl_q[UPDATE_BIT];
    zero_hit = 1'b0;
    run_d    = run_q;
    fix_d    = fix_q;

    if (fix_we) fix_d = wdata[CNT_W-1:0];

    if (load_now) begin
      run_d = wdata[CNT_W-1:0];
    end else if (tick) begin
      if (run_q != CNT_ZERO) begin
        run_d    = run_q - CNT_ONE;
        zero_hit = (run_q == CNT_ONE);
      end else if (ctrl_q[RELOAD_BIT]) begin
        run_d = fix_q;
      end
    end

    ctrl_d = ctrl_mod;
    if (zero_hit) ctrl_d[ST_BIT] = 1'b1;

    ctrl_en = ctrl_we | zero_hit;
    run_en  = load_now | tick;
    fix_en  = fix_we;

    if (soft_clr) begin
      ctrl_d  = '0;
      run_d   = '0;
      fix_d   = '0;
      ctrl_en = 1'b1;
      run_en  = 1'b1;
      fix_en  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      run_q  <= '0;
      fix_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (run_en)  run_q  <= run_d;
      if (fix_en)  fix_q  <= fix_d;
    end
  end

  assign irq_req = ctrl_q[ST_BIT] & ctrl_q[IE_BIT];

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              slow_tick,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] GLB_A = '0;
  localparam logic [ADDR_W-1:0] VER_A = ADDR_W'(CH_BASE + NUM_CH * CH_STRIDE);
  localparam logic [BUS_W-1:0]  VER_WORD = {VER_MAJOR, 24'h0};

  logic [NUM_CH-1:0][BUS_W-1:0] ctrl_all;
  logic [NUM_CH-1:0][CNT_W-1:0] run_all;
  logic [NUM_CH-1:0][CNT_W-1:0] fix_all;
  logic [NUM_CH-1:0]            ctrl_hit;
  logic [NUM_CH-1:0]            run_hit;
  logic [NUM_CH-1:0]            fix_hit;
  logic [NUM_CH-1:0]            irq_req;
  logic                         soft_clr;
  ctrl_op_e                     ctrl_op;

  assign soft_clr = bus_wr && (bus_addr == GLB_A) && bus_wdata[SRST_BIT];
  assign ctrl_op  = ctrl_op_e'(bus_addr[3:2]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CH_BASE + i * CH_STRIDE);
    localparam logic [ADDR_W-1:0] RUN_A  = ADDR_W'(CH_BASE + i * CH_STRIDE + RUN_OFF);
    localparam logic [ADDR_W-1:0] FIX_A  = ADDR_W'(CH_BASE + i * CH_STRIDE + FIX_OFF);

    assign ctrl_hit[i] = (bus_addr[ADDR_W-1:4] == CTRL_A[ADDR_W-1:4]) &&
                         (bus_addr[1:0] == 2'b00);
    assign run_hit[i]  = (bus_addr == RUN_A);
    assign fix_hit[i]  = (bus_addr == FIX_A);

    dtmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .slow_tick (slow_tick),
      .ctrl_we   (bus_wr && ctrl_hit[i]),
      .ctrl_op   (ctrl_op),
      .fix_we    (bus_wr && fix_hit[i]),
      .wdata     (bus_wdata),
      .ctrl_q    (ctrl_all[i]),
      .run_q     (run_all[i]),
      .fix_q     (fix_all[i]),
      .irq_req   (irq_req[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == VER_A) bus_rdata = VER_WORD;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctrl_hit[i]) bus_rdata = ctrl_all[i];
      if (run_hit[i])  bus_rdata = BUS_W'(run_all[i]);
      if (fix_hit[i])  bus_rdata = BUS_W'(fix_all[i]);
    end
  end

  assign irq = |irq_req;

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [BUS_W-1:0]             bus_wdata,
  input logic [NUM_CH-1:0][BUS_W-1:0] ctrl_all,
  input logic [NUM_CH-1:0][CNT_W-1:0] run_all,
  input logic [NUM_CH-1:0][CNT_W-1:0] fix_all
);

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[SRST_BIT]) |=>
      (ctrl_all == '0 && run_all == '0 && fix_all == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CH_BASE + i * CH_STRIDE);
    localparam logic [ADDR_W-1:0] FIX_A  = ADDR_W'(CH_BASE + i * CH_STRIDE + FIX_OFF);

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && ctrl_all[i][3:0] == 4'hF && run_all[i] != '0) |=>
        (run_all[i] == $past(run_all[i]) - CNT_W'(1)));

    // R3
    flag_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && ctrl_all[i][3:0] == 4'hF && run_all[i] == CNT_W'(1)) |=>
        ctrl_all[i][ST_BIT]);

    // R3
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !ctrl_all[i][RELOAD_BIT] && run_all[i] == '0) |=>
        (run_all[i] == '0));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && ctrl_all[i][3:0] == 4'hF && ctrl_all[i][RELOAD_BIT] &&
       run_all[i] == '0) |=> (run_all[i] == $past(fix_all[i])));

    // R5
    update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == FIX_A && ctrl_all[i][UPDATE_BIT]) |=>
        (run_all[i] == $past(bus_wdata[CNT_W-1:0])));

    // R6
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == (CTRL_A + ADDR_W'(8)) && bus_wdata[IE_BIT]) |=>
        !ctrl_all[i][IE_BIT]);
  end

endmodule

bind dual_down_timer dtmr_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctrl_all  (ctrl_all),
  .run_all   (run_all),
  .fix_all   (fix_all)
);

// File: tb/dual_down_timer_tb_top.sv
`timescale 1ns/1ps
module dual_down_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        slow_tick;
  logic        irq;

  int n_chk;
  int n_err;
  bit done;

  localparam logic [11:0] C0 = 12'h020, R0 = 12'h030, F0 = 12'h040;
  localparam logic [11:0] C1 = 12'h060, R1A = 12'h070, F1 = 12'h080;
  localparam logic [11:0] VER = 12'h0A0;
  localparam logic [11:0] SETO = 12'h4, CLRO = 12'h8, TGLO = 12'hC;

  dual_down_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .slow_tick (slow_tick),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl0", C0, 0);
    expect_reg("R1 run0", R0, 0);
    expect_reg("R1 fix0", F0, 0);
    expect_reg("R1 ctrl1", C1, 0);
    expect_reg("R1 version", VER, 32'h0200_0000);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count;
    wr(C0, 32'h80);
    wr(F0, 5);
    expect_reg("R5 load on update", R0, 5);
    step(3);
    expect_reg("R2 select 0 holds", R0, 5);
    wr(C0 + SETO, 32'hF);
    expect_reg("R2 no tick on select edge", R0, 5);
    step(4);
    expect_reg("R2 down by four", R0, 1);
    expect_reg("R3 flag not yet", C0, 32'h8F);
    step(1);
    expect_reg("R3 at zero", R0, 0);
    expect_reg("R3 flag set", C0, 32'h808F);
    step(3);
    expect_reg("R3 one-shot stays zero", R0, 0);
  endtask

  task automatic t_irq;
    wr(C0 + SETO, 32'h4000);
    check("R7 irq high", {31'b0, irq}, 1);
    wr(C0 + CLRO, 32'h8000);
    check("R7 irq low after ack", {31'b0, irq}, 0);
    expect_reg("R6 clear alias keeps others", C0, 32'h408F);
  endtask

  task automatic t_reload;
    wr(C0, 32'hCF);
    wr(F0, 2);
    expect_reg("R5 load", R0, 2);
    step(1);
    expect_reg("R4 count 1", R0, 1);
    step(1);
    expect_reg("R4 count 0", R0, 0);
    step(1);
    expect_reg("R4 reloaded", R0, 2);
    wr(C0 + CLRO, 32'hF);
    expect_reg("R6 clear select", C0, 32'h80C0);
    expect_reg("R2 last tick", R0, 1);
    wr(C0 + CLRO, 32'h80);
    wr(F0, 7);
    expect_reg("R5 no update keeps run", R0, 1);
    expect_reg("R5 fix written", F0, 7);
    wr(C0 + SETO, 32'hF);
    step(2);
    expect_reg("R4 reload new value", R0, 7);
    wr(C0 + CLRO, 32'hF);
    expect_reg("R2 stopped", R0, 6);
  endtask

  task automatic t_slow;
    wr(C1, 32'h8B);
    wr(F1, 3);
    step(3);
    expect_reg("R2 slow idle", R1A, 3);
    slow_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    slow_tick = 1'b0;
    expect_reg("R2 slow one tick", R1A, 2);
    step(2);
    expect_reg("R2 slow holds", R1A, 2);
  endtask

  task automatic t_wrap;
    wr(C1, 32'h80);
    wr(F1, 1);
    wr(C1 + CLRO, 32'h80);
    wr(F1, 32'hFFFF_FFFF);
    expect_reg("R5 run kept", R1A, 1);
    wr(C1 + SETO, 32'h4F);
    step(1);
    expect_reg("R3 ch1 zero flag", C1, 32'h804F);
    step(1);
    expect_reg("R4 wrap full range", R1A, 32'hFFFF_FFFF);
    step(1);
    expect_reg("R4 after wrap", R1A, 32'hFFFF_FFFE);
  endtask

  task automatic t_alias;
    wr(C1 + TGLO, 32'hF);
    expect_reg("R6 toggle select", C1, 32'h8040);
    expect_reg("R2 stopped ch1", R1A, 32'hFFFF_FFFD);
    wr(C1 + TGLO, 32'h4000);
    expect_reg("R6 toggle enable", C1, 32'hC040);
    check("R7 irq from ch1", {31'b0, irq}, 1);
    wr(C1 + SETO, 32'hFFFF_3F30);
    expect_reg("R6 absent bits stay 0", C1, 32'hC040);
  endtask

  task automatic t_readonly;
    wr(R1A, 32'h1234);
    expect_reg("R10 run unchanged", R1A, 32'hFFFF_FFFD);
    expect_reg("R10 fix unchanged", F1, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide;
    wr(C0, 32'h80);
    wr(F0, 2);
    wr(C0 + SETO, 32'hF);
    step(1);
    expect_reg("R9 pre count", R0, 1);
    wr(C0 + CLRO, 32'h8000);
    expect_reg("R9 flag wins over clear", C0, 32'h808F);
    expect_reg("R9 reached zero", R0, 0);
    wr(F0, 9);
    step(1);
    expect_reg("R9 pre load", R0, 8);
    wr(F0, 4);
    expect_reg("R9 load wins over tick", R0, 4);
    wr(C0 + CLRO, 32'hF);
    expect_reg("R9 stopped", R0, 3);
  endtask

  task automatic t_softrst;
    wr(12'h000, 32'h8000_0000);
    expect_reg("R8 ctrl0", C0, 0);
    expect_reg("R8 run0", R0, 0);
    expect_reg("R8 fix0", F0, 0);
    expect_reg("R8 ctrl1", C1, 0);
    expect_reg("R8 run1", R1A, 0);
    expect_reg("R8 fix1", F1, 0);
    expect_reg("R8 global reads 0", 12'h000, 0);
    check("R8 irq low", {31'b0, irq}, 0);
    expect_reg("R1 version kept", VER, 32'h0200_0000);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; slow_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_irq;
    t_reload;
    t_slow;
    t_wrap;
    t_alias;
    t_readonly;
    t_collide;
    t_softrst;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule